// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block turns a fixed core clock into the timing grid of an I2C master. Two prescaler stages are cascaded. The first divides the core clock by (m+1). The second divides the result by 2^(n+1). Each output tick therefore marks one tenth of an SCL period, so the SCL frequency is core clock / (10 · (m+1) · 2 · 2^n).

A mod-10 phase counter advances on every tick, so the master engine can place the SCL low and high halves and the setup and hold points of start and stop conditions on fixed phase numbers.

The divide setting is a packed rate code loaded through a single-cycle write strobe. Every load restarts both prescaler stages, so the first period after a change is a full one. A synchronous soft reset returns the rate code to its power-on value and clears all counters.

Top module: `i2c_rate_gen`

## Requirements
- R1: After reset the rate code is 0x44 (m=8, n=4), the phase is 0, and the first tick appears 288 core clocks after reset is released.
- R2: With the rate code held, `tick` is high for exactly one core clock in every (m+1)·2^(n+1) core clocks.
- R3: In `rate_wdata`, bits [6:3] carry m and bits [2:0] carry n; bit 7 has no effect on the tick period.
- R4: A load, meaning `rate_we` high at a clock edge, clears both prescaler stages at that edge. The next tick comes a full new period later, counted from that edge. A tick present in the load cycle still counts.
- R5: `phase` steps 0,1,…,9,0 by one on each cycle where `tick` is high, and holds its value otherwise.
- R6: `scl_hi` is 0 while `phase` is 0 to 4 and 1 while `phase` is 5 to 9.
- R7: `soft_rst` high at an edge restores rate code 0x44, clears the prescalers and the phase, and takes priority over a simultaneous load.
- R8: The extreme codes give the extreme periods: m=0,n=0 gives a tick every 2 clocks, and m=15,n=7 gives one every 4096 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to the power-on rate code |
| rate_we | input | 1 | Load strobe for the rate code |
| rate_wdata | input | 8 | Rate code: m in [6:3], n in [2:0] |
| tick | output | 1 | One-cycle pulse, ten per SCL period |
| phase | output | 4 | Position within the SCL period, 0 to 9 |
| scl_hi | output | 1 | High half of the SCL period |

## Verification
The hardest case to reach is a load that lands in the exact cycle in which a tick is being issued. That tick must still advance the phase, while the counters restart under the new code. The stimulus reaches it by watching the reference model: the bench waits until the model predicts a tick, then drives the strobe for that edge. Loads placed mid-period, and a soft reset asserted together with a load, are also driven. Every output is compared on every clock against a single flat period counter in the bench.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
   localparam int unsigned DEF_M_W     = 4;
   localparam int unsigned DEF_N_W     = 3;
   localparam int unsigned DEF_WDATA_W = 8;
   localparam int unsigned DEF_PHASES  = 10;
   localparam int unsigned DEF_LOW     = 5;

   typedef enum logic {
      SCL_LOW  = 1'b0,
      SCL_HIGH = 1'b1
   } scl_lvl_e;
endpackage

// File: rtl/i2c_rate_lin_stage.sv
module i2c_rate_lin_stage #(
   parameter int unsigned M_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [M_W-1:0] lim,
   output logic           pulse
);
   logic [M_W-1:0] cnt;

   assign pulse = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (pulse) cnt <= '0;
      else            cnt <= cnt + M_W'(1);
   end

   // R4: the counter never runs past its limit, even across a load
   a_r4_lin_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
   // R4: a clear restarts the count
   a_r4_lin_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/i2c_rate_pow_stage.sv
module i2c_rate_pow_stage #(
   parameter int unsigned N_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           step,
   input  logic [N_W-1:0] exp_n,
   output logic           tick
);
   localparam int unsigned C_W = 1 << N_W;

   logic [C_W-1:0] mask;
   logic [C_W-1:0] cnt;

   // thermometer mask: 2^(n+1)-1
   for (genvar i = 0; i < C_W; i++) begin : g_mask
      localparam logic [N_W-1:0] IDX = N_W'(i);
      assign mask[i] = (IDX <= exp_n);
   end

   assign tick = step && (cnt == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (tick)     cnt <= '0;
      else if (step)     cnt <= cnt + C_W'(1);
   end

   // R4: the count stays inside the power-of-two window
   a_r4_pow_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt & ~mask) == '0);
   // R2: without a step the count holds
   a_r2_pow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(cnt));
endmodule

// File: rtl/i2c_rate_phase.sv
module i2c_rate_phase #(
   parameter int unsigned PHASES = 10,
   parameter int unsigned LOW    = 5,
   localparam int unsigned PH_W  = $clog2(PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            adv,
   output logic [PH_W-1:0] ph,
   output logic            hi
);
   import i2c_rate_pkg::*;

   scl_lvl_e lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ph <= '0;
      else if (clr)                        ph <= '0;
      else if (adv) begin
         if (ph == PH_W'(PHASES - 1))      ph <= '0;
         else                              ph <= ph + PH_W'(1);
      end
   end

   assign lvl = (ph >= PH_W'(LOW)) ? SCL_HIGH : SCL_LOW;
   assign hi  = (lvl == SCL_HIGH);

   // R5: phase stays in range
   a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
      ph < PH_W'(PHASES));
   // R5: wrap after the last phase
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && ph == PH_W'(PHASES - 1)) |=> (ph == '0));
   // R5: no tick, no step
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(ph));
   // R6: the high half starts at the LOW boundary
   a_r6_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi) |-> (ph == PH_W'(LOW)));
endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
   parameter int unsigned M_W      = i2c_rate_pkg::DEF_M_W,
   parameter int unsigned N_W      = i2c_rate_pkg::DEF_N_W,
   parameter int unsigned WDATA_W  = i2c_rate_pkg::DEF_WDATA_W,
   parameter int unsigned PHASES   = i2c_rate_pkg::DEF_PHASES,
   parameter int unsigned LOW      = i2c_rate_pkg::DEF_LOW,
   parameter logic [M_W+N_W-1:0] RST_CODE = 'h44,
   localparam int unsigned CODE_W  = M_W + N_W,
   localparam int unsigned PH_W    = $clog2(PHASES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               rate_we,
   input  logic [WDATA_W-1:0] rate_wdata,
   output logic               tick,
   output logic [PH_W-1:0]    phase,
   output logic               scl_hi
);
   if (WDATA_W < CODE_W) begin : g_bad_wdata
      $error("rate_wdata narrower than the rate code");
   end
   if (LOW == 0 || LOW >= PHASES) begin : g_bad_low
      $error("LOW must split the phase range");
   end

   logic [CODE_W-1:0] code_q;
   logic [M_W-1:0]    m_q;
   logic [N_W-1:0]    n_q;
   logic              clr;
   logic              p1;

   assign clr = soft_rst | rate_we;
   assign m_q = code_q[CODE_W-1:N_W];
   assign n_q = code_q[N_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= RST_CODE;
      else if (soft_rst) code_q <= RST_CODE;
      else if (rate_we)  code_q <= rate_wdata[CODE_W-1:0];
   end

   i2c_rate_lin_stage #(.M_W(M_W)) u_lin (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lim(m_q), .pulse(p1));

   i2c_rate_pow_stage #(.N_W(N_W)) u_pow (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(p1), .exp_n(n_q),
      .tick(tick));

   i2c_rate_phase #(.PHASES(PHASES), .LOW(LOW)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .adv(tick),
      .ph(phase), .hi(scl_hi));

   // R4: a period is at least two clocks, so no tick follows a load directly
   a_r4_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rate_we |=> !tick);
   // R7: soft reset clears the phase and the tick
   a_r7_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (phase == '0 && !tick));
   // R7: soft reset beats a simultaneous load
   a_r7_soft_prio: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (code_q == RST_CODE));
endmodule

// File: tb/tb_i2c_rate_gen.sv
module tb_i2c_rate_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       rate_we = 1'b0;
   logic [7:0] rate_wdata = 8'h00;
   logic       tick;
   logic [3:0] phase;
   logic       scl_hi;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   string cur_req = "R1";
   bit    done  = 1'b0;

   // reference model: one flat period counter
   int mp = 288;
   int mk = 0;
   int mph = 0;

   always #5 clk = ~clk;

   i2c_rate_gen dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rate_we(rate_we),
      .rate_wdata(rate_wdata), .tick(tick), .phase(phase), .scl_hi(scl_hi));

   function automatic int period_of(input logic [7:0] c);
      return (int'(c[6:3]) + 1) << (int'(c[2:0]) + 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         mp = period_of(8'h44); mk = 0; mph = 0;
      end else begin
         if (mk == mp - 1) mph = (mph + 1) % 10;
         if (rate_we) begin mp = period_of(rate_wdata); mk = 0; end
         else mk = (mk + 1) % mp;
      end
      cyc++;
   end

   task automatic cmp(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp(cur_req, "tick", int'(tick), (mk == mp - 1) ? 1 : 0);
         cmp("R5", "phase", int'(phase), mph);
         cmp("R6", "scl_hi", int'(scl_hi), (mph >= 5) ? 1 : 0);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load(input logic [7:0] c);
      @(negedge clk);
      rate_we = 1'b1; rate_wdata = c;
      @(negedge clk);
      rate_we = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      cmp("R1", "reset tick", int'(tick), 0);
      cmp("R1", "reset phase", int'(phase), 0);
      cmp("R1", "reset scl_hi", int'(scl_hi), 0);
      rst_n = 1'b1;
      cur_req = "R1"; idle(900);
      cur_req = "R8"; load(8'h00); idle(60);
      cur_req = "R2"; load(8'h13); idle(500);
      cur_req = "R3"; load(8'hC4); idle(700);
      // R4: reloads in the middle of a period
      cur_req = "R4"; load(8'h09); idle(5);
      load(8'h0A); idle(3);
      load(8'h09); idle(100);
      // R4: load in the very cycle of a tick
      while (mk != mp - 1) @(negedge clk);
      rate_we = 1'b1; rate_wdata = 8'h12;
      @(negedge clk);
      rate_we = 1'b0;
      idle(200);
      cur_req = "R5"; load(8'h01); idle(120);
      // R7: soft reset together with a load
      cur_req = "R7"; idle(7);
      @(negedge clk);
      soft_rst = 1'b1; rate_we = 1'b1; rate_wdata = 8'h00;
      @(negedge clk);
      soft_rst = 1'b0; rate_we = 1'b0;
      idle(600);
      cur_req = "R8"; load(8'h7F); idle(8400);
      finish_run();
   end

   initial begin
      while (cyc < 150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
         finish_run();
      end
   end
endmodule